// File: doc/BRIEF.md
# UART Receive FIFO Error Tracker

This block is the receive-side character store of a UART, together with the logic that produces the error-related line-status bits. Each received character enters with three tags: parity error, framing error and break. The tags travel with the byte through a 16-deep queue. The per-character status bits and the receive-line-status interrupt always describe the character waiting at the head of the queue, not the most recent arrival. A tagged byte sitting behind clean bytes stays silent until the processor has read the bytes ahead of it.

The block also keeps a queue-wide error summary, computed as a count of tagged entries. This summary does not clear when the processor reads line status. It falls only when the last tagged byte has been popped, and it never raises the interrupt on its own.

A break strobe from the deserializer goes high once the line has been held at 0 for longer than a full frame (start, data, parity and stop bits). The rising edge of that strobe loads a single 0x00 byte carrying the break tag. With queue mode off the store behaves as a single holding register.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: After reset the store is empty, and every status output and the interrupt is 0.
- R2: With `fifo_en_i`=1 the store holds up to DEPTH (16) bytes and returns them in arrival order. With `fifo_en_i`=0 it holds a single byte.
- R3: A write that arrives while the store is full and no read is taking place drops the byte and sets `overrun_o`. A line-status read clears `overrun_o`.
- R4: `fifo_err_o` is 1 in queue mode while any stored byte carries a parity, framing or break tag. It is always 0 when `fifo_en_i`=0.
- R5: A line-status read leaves `fifo_err_o` unchanged. `fifo_err_o` falls in the cycle after the last tagged byte is read out.
- R6: `perr_o`, `ferr_o` and `brk_o` show the tags of the head byte, and `rx_data_o` shows its data.
- R7: `rls_irq_o` is the OR of `perr_o`, `ferr_o`, `brk_o` and `overrun_o`. A tagged byte behind an untagged head does not raise it.
- R8: A line-status read while a byte is present clears `perr_o`, `ferr_o` and `brk_o` for that head byte. A new head byte shows its own tags again.
- R9: A rising edge on `brk_i` stores exactly one 0x00 byte with the break tag, however long `brk_i` stays high. On that cycle the break edge takes priority over `wr_valid_i`.
- R10: A change of `fifo_en_i` empties the store and clears the tag count in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | 1 = queue mode, 0 = single holding register |
| wr_valid_i | input | 1 | Received character strobe |
| wr_data_i | input | 8 | Received character |
| wr_perr_i | input | 1 | Parity error tag of the character |
| wr_ferr_i | input | 1 | Framing error tag of the character |
| brk_i | input | 1 | Break-detected level from the deserializer |
| rd_i | input | 1 | Processor data read (pops the head) |
| lsr_rd_i | input | 1 | Processor line-status read |
| rx_data_o | output | 8 | Head character data (0 when empty) |
| rx_ready_o | output | 1 | Store not empty |
| fifo_err_o | output | 1 | Some stored byte is tagged (queue mode only) |
| perr_o | output | 1 | Head byte parity error |
| ferr_o | output | 1 | Head byte framing error |
| brk_o | output | 1 | Head byte break indication |
| overrun_o | output | 1 | A byte was dropped on a full store |
| rls_irq_o | output | 1 | Receive-line-status interrupt |

## Verification
The bound checker watches several rules on every cycle. The tag count never exceeds the occupancy, and the occupancy never exceeds the mode's limit. A dropped write always sets the overrun flag. A line-status read leaves the summary bit intact and clears the head flags. With the store empty, the interrupt equals the overrun flag. Other behaviour can be shown only by the bench's scenarios against its scoreboard: that the interrupt waits for a tagged byte to reach the head, that a long break yields a single byte, that data comes out in arrival order, and that a mode change flushes the store.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rxf_entry_t;

  function automatic logic is_tagged(rxf_entry_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             limit_one_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  rxf_entry_t       wdata_i,
  output rxf_entry_t       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             drop_o
);
  rxf_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             full, empty;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count_q == '0);
  assign full      = limit_one_i ? !empty : (count_q == CNT_W'(DEPTH));
  assign pop_ok_o  = pop_i & !empty & !flush_i;
  assign push_ok_o = push_i & !flush_i & (!full | pop_ok_o);
  assign drop_o    = push_i & !flush_i & !push_ok_o;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok_o, pop_ok_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/rxf_tag_cnt.sv
module rxf_tag_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_perr_i,
  input  logic              wr_ferr_i,
  input  logic              brk_i,
  input  logic              rd_i,
  input  logic              lsr_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              fifo_err_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o,
  output logic              overrun_o,
  output logic              rls_irq_o
);
  logic             fifo_en_q, brk_q, ack_q, ovr_q;
  logic             flush, brk_rise, push, push_ok, pop_ok, drop;
  logic [CNT_W-1:0] count, tag_cnt;
  rxf_entry_t       wentry, head;

  assign flush    = fifo_en_i ^ fifo_en_q;
  assign brk_rise = brk_i & ~brk_q;
  assign push     = wr_valid_i | brk_rise;

  // break edge wins over a simultaneous character
  always_comb begin
    if (brk_rise) begin
      wentry = '0;
      wentry.brk = 1'b1;
    end else begin
      wentry.brk  = 1'b0;
      wentry.ferr = wr_ferr_i;
      wentry.perr = wr_perr_i;
      wentry.data = wr_data_i;
    end
  end

  rxf_store #(.DEPTH(DEPTH)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .limit_one_i(~fifo_en_q),
    .push_i     (push),
    .pop_i      (rd_i),
    .wdata_i    (wentry),
    .head_o     (head),
    .count_o    (count),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .drop_o     (drop)
  );

  rxf_tag_cnt #(.CNT_W(CNT_W)) i_tag_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush),
    .inc_i  (push_ok & is_tagged(wentry)),
    .dec_i  (pop_ok & is_tagged(head)),
    .cnt_o  (tag_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      brk_q     <= 1'b0;
      ack_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en_i;
      brk_q     <= brk_i;
      // head flags are acknowledged until the head changes
      if (flush || pop_ok)          ack_q <= 1'b0;
      else if (lsr_rd_i && rx_ready_o) ack_q <= 1'b1;
      if (drop)          ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
    end
  end

  assign rx_ready_o = (count != '0);
  assign rx_data_o  = head.data;
  assign perr_o     = rx_ready_o & head.perr & ~ack_q;
  assign ferr_o     = rx_ready_o & head.ferr & ~ack_q;
  assign brk_o      = rx_ready_o & head.brk & ~ack_q;
  assign overrun_o  = ovr_q;
  assign fifo_err_o = fifo_en_i & fifo_en_q & (tag_cnt != '0);
  assign rls_irq_o  = perr_o | ferr_o | brk_o | overrun_o;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             fifo_en_q,
  input logic             rd_i,
  input logic             lsr_rd_i,
  input logic             drop,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] tag_cnt,
  input logic             rx_ready_o,
  input logic             fifo_err_o,
  input logic             perr_o,
  input logic             ferr_o,
  input logic             brk_o,
  input logic             overrun_o,
  input logic             rls_irq_o
);
  // R2
  count_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= (fifo_en_q ? CNT_W'(DEPTH) : CNT_W'(1)));

  // R3
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> overrun_o);

  // R4
  tag_le_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_cnt <= count);

  // R4
  err_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_err_o |-> rx_ready_o);

  // R5
  err_survives_lsr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_err_o && lsr_rd_i && !rd_i) |=> (fifo_err_o || !fifo_en_i));

  // R8
  lsr_clears_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && rx_ready_o && !rd_i && fifo_en_i == fifo_en_q)
      |=> !(perr_o || ferr_o || brk_o));

  // R7
  empty_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_o |-> (rls_irq_o == overrun_o));
endmodule

bind uart_rx_err_fifo rxf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_en_i (fifo_en_i),
  .fifo_en_q (fifo_en_q),
  .rd_i      (rd_i),
  .lsr_rd_i  (lsr_rd_i),
  .drop      (drop),
  .count     (count),
  .tag_cnt   (tag_cnt),
  .rx_ready_o(rx_ready_o),
  .fifo_err_o(fifo_err_o),
  .perr_o    (perr_o),
  .ferr_o    (ferr_o),
  .brk_o     (brk_o),
  .overrun_o (overrun_o),
  .rls_irq_o (rls_irq_o)
);

// File: tb/test_uart_rx_err_fifo.sv
module test_uart_rx_err_fifo;
  localparam int DEPTH = 16;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       fifo_en = 1'b0, wr_valid = 1'b0, wr_perr = 1'b0, wr_ferr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       brk = 1'b0, rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, fifo_err, perr, ferr, brk_flag, overrun, irq;

  always #10 clk = ~clk;

  uart_rx_err_fifo #(.DEPTH(DEPTH)) i_uart_rx_err_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_perr_i(wr_perr), .wr_ferr_i(wr_ferr), .brk_i(brk),
    .rd_i(rd), .lsr_rd_i(lsr_rd), .rx_data_o(rx_data), .rx_ready_o(rx_ready),
    .fifo_err_o(fifo_err), .perr_o(perr), .ferr_o(ferr), .brk_o(brk_flag),
    .overrun_o(overrun), .rls_irq_o(irq)
  );

  typedef struct {
    logic [7:0] d;
    bit p, f, b;
  } item_t;

  item_t exp_q[$];
  bit    ack_exp = 0, ovr_exp = 0;
  int    n_chk = 0, n_bad = 0;
  bit    finished = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    bit any_tag = 0;
    bit hp = 0, hf = 0, hb = 0;
    foreach (exp_q[i]) any_tag |= exp_q[i].p | exp_q[i].f | exp_q[i].b;
    if (exp_q.size() > 0 && !ack_exp) begin
      hp = exp_q[0].p; hf = exp_q[0].f; hb = exp_q[0].b;
    end
    check({req, " ready"},    rx_ready, exp_q.size() > 0);
    check({req, " fifo_err"}, fifo_err, fifo_en & any_tag);
    check({req, " perr"},     perr, hp);
    check({req, " ferr"},     ferr, hf);
    check({req, " brk"},      brk_flag, hb);
    check({req, " overrun"},  overrun, ovr_exp);
    check({req, " irq"},      irq, hp | hf | hb | ovr_exp);
  endtask

  // driver: push one character, record expectation
  task automatic push_byte(logic [7:0] d, bit p, bit f);
    item_t it;
    @(negedge clk);
    wr_valid = 1; wr_data = d; wr_perr = p; wr_ferr = f;
    @(posedge clk); #1;
    wr_valid = 0; wr_perr = 0; wr_ferr = 0;
    it.d = d; it.p = p; it.f = f; it.b = 0;
    if (exp_q.size() < (fifo_en ? DEPTH : 1)) exp_q.push_back(it);
    else ovr_exp = 1;
  endtask

  // monitor: compare head against scoreboard, then pop
  task automatic pop_check(string req);
    item_t it;
    @(negedge clk);
    it = exp_q.pop_front();
    check({req, " data"}, rx_data, it.d);
    check({req, " head perr"}, perr, it.p & !ack_exp);
    check({req, " head ferr"}, ferr, it.f & !ack_exp);
    check({req, " head brk"},  brk_flag, it.b & !ack_exp);
    rd = 1;
    @(posedge clk); #1;
    rd = 0;
    ack_exp = 0;
  endtask

  task automatic lsr_read();
    @(negedge clk);
    lsr_rd = 1;
    @(posedge clk); #1;
    lsr_rd = 0;
    ovr_exp = 0;
    if (exp_q.size() > 0) ack_exp = 1;
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    fifo_en = m;
    @(posedge clk); #1;
    exp_q.delete();
    ack_exp = 0;
  endtask

  initial begin
    item_t bi;
    #5 rst_ni = 0;
    #30 rst_ni = 1;
    @(posedge clk); #1;
    check_flags("R1 reset");

    set_mode(1);
    check_flags("R10 empty after enable");

    // tagged byte behind clean head stays silent
    push_byte(8'h11, 0, 0);
    push_byte(8'h22, 0, 0);
    push_byte(8'h33, 1, 0);
    check_flags("R7 tag behind head");
    check("R7 no irq from summary", irq, 0);
    pop_check("R2 first");
    check_flags("R6 second head");
    pop_check("R2 second");
    check_flags("R6 parity head");
    check("R7 irq at head", irq, 1);
    lsr_read();
    check_flags("R8 after lsr");
    check("R5 summary kept", fifo_err, 1);
    pop_check("R6 parity pop");
    check_flags("R5 summary drained");

    // fill and overrun
    for (int i = 0; i < DEPTH; i++) push_byte(8'(8'h40 + i), 0, (i == 5));
    check("R2 full ready", rx_ready, 1);
    push_byte(8'hEE, 0, 0);
    check_flags("R3 overrun");
    lsr_read();
    check_flags("R3 overrun cleared");
    for (int i = 0; i < DEPTH; i++) begin
      pop_check("R2 order");
      check_flags("R5 drain");
    end

    // long break -> one byte
    @(negedge clk);
    brk = 1;
    bi.d = 8'h00; bi.p = 0; bi.f = 0; bi.b = 1;
    exp_q.push_back(bi);
    repeat (40) @(negedge clk);
    brk = 0;
    push_byte(8'h5A, 0, 0);
    check_flags("R9 break head");
    check("R9 break data", rx_data, 0);
    pop_check("R9 break pop");
    check_flags("R9 single entry");
    pop_check("R9 following byte");
    check("R9 empty", rx_ready, 0);

    // flush on mode change, single holding register
    push_byte(8'h77, 0, 1);
    check_flags("R4 framing in queue");
    set_mode(0);
    check_flags("R10 flushed");
    push_byte(8'h81, 0, 1);
    check_flags("R4 no summary in single mode");
    push_byte(8'h82, 0, 0);
    check_flags("R2 single holds one");
    check("R3 single overrun", overrun, 1);
    pop_check("R2 single data");
    lsr_read();
    check_flags("R3 cleared single");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule